// File: doc/BRIEF.md
# CompactFlash True-IDE PIO Cycle Timer

This block turns a single host access into one programmed-I/O register cycle on a CompactFlash card in true-IDE mode. The host raises a request and presents a direction bit, a chip-select choice, a 3-bit register address and 16-bit write data. The block then drives the card's address lines, the selected chip select, and either the read or the write strobe. On reads it captures the card's data bus. It reports completion with a done signal.

All three timing intervals are counted in clocks of the block's own clock. The setup interval runs from chip select to the falling strobe. The width interval is the time the strobe stays low. The hold interval runs from the rising strobe to the release of chip select. The card's optional ready line freezes the width count while it is low. This lets a slow card stretch the strobe, and the fixed count is still enough when ready is tied high. Done stays asserted until the host drops its request. A new request is taken only after that drop has been seen and the hold interval has ended.

The integrator chooses the three counts from the clock period so that they meet the card's 70 ns setup, 165 ns strobe width and 20 ns hold minimums. The data bus driver toward the card is enabled only for writes. This leaves the bus free for the card's read data.

Top module: `cf_pio_timer`

## Requirements
- R1: The clock edge that samples `req_i` high in the idle state accepts the request. From the cycle after that edge, the chip select picked by `req_sel_i` is driven low (0 selects `cf_cs_n_o[0]`, 1 selects `cf_cs_n_o[1]`), and the other chip select stays high. The strobe falls exactly SETUP_CYC cycles after that chip select falls.
- R2: A read (`req_we_i`=0) pulses only `cf_rd_n_o`, and a write (`req_we_i`=1) pulses only `cf_wr_n_o`. With `cf_ready_i` high, the strobe stays low for exactly WIDTH_CYC cycles.
- R3: Each clock edge during the strobe at which `cf_ready_i` is sampled low lengthens the strobe by one cycle. A low ready outside the strobe has no effect on any output.
- R4: After the strobe rises, chip select, address and (on writes) the data driver stay active for exactly HOLD_CYC cycles. Then chip select returns high.
- R5: `done_o` rises in the cycle the strobe rises. It stays high while `req_i` is high, and it falls in the cycle after `req_i` is sampled low. No strobe is active while `done_o` is high.
- R6: On a read, `rdata_o` takes the value of `cf_data_i` sampled at the clock edge that ends the strobe. It keeps that value until the next read ends, and writes leave it unchanged.
- R7: `cf_data_oe_o` is high only during write cycles, from chip select assertion to chip select release. `cf_data_o` carries the write data captured at acceptance.
- R8: `cf_addr_o[2:0]` carries the register address captured at acceptance, and `cf_addr_o[10:3]` is always zero.
- R9: A request held high after done does not start another cycle. A new cycle starts only after `req_i` has been sampled low and the hold interval has ended.
- R10: During and right after reset, both chip selects and both strobes are high, `cf_data_oe_o` and `done_o` are low, and `cf_addr_o` and `rdata_o` are zero.
- R11: Changes to `req_we_i`, `req_sel_i`, `req_addr_i` or `req_wdata_i` after acceptance have no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access request, held until done |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_sel_i | input | 1 | Chip select choice |
| req_addr_i | input | 3 | Card register address |
| req_wdata_i | input | 16 | Write data |
| done_o | output | 1 | Cycle complete, held until request drops |
| rdata_o | output | 16 | Captured read data |
| cf_addr_o | output | 11 | Card address lines |
| cf_cs_n_o | output | 2 | Card chip selects, active low |
| cf_rd_n_o | output | 1 | Read strobe, active low |
| cf_wr_n_o | output | 1 | Write strobe, active low |
| cf_data_o | output | 16 | Data toward card |
| cf_data_oe_o | output | 1 | Data bus output enable |
| cf_data_i | input | 16 | Data from card |
| cf_ready_i | input | 1 | Card ready, low stretches the strobe |

## Verification
The bench builds the block with SETUP_CYC=2, WIDTH_CYC=4 and HOLD_CYC=3. The three counts are distinct, so a setup, width or hold interval taken from the wrong count shows up as a wrong cycle distance. The small values keep each access short. That leaves room for many accesses with ready stalls inside the strobe, ready dropped during setup, requests released early during the hold, and requests held long after done.

// File: rtl/cfpio_pkg.sv
package cfpio_pkg;

  typedef enum logic [4:0] {
    PH_IDLE    = 5'b00001,
    PH_SETUP   = 5'b00010,
    PH_STROBE  = 5'b00100,
    PH_HOLD    = 5'b01000,
    PH_RELEASE = 5'b10000
  } cfpio_phase_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // number of counted clocks spent in a phase before it ends
  function automatic int unsigned phase_span(input cfpio_phase_e ph, input int unsigned s,
                                             input int unsigned w, input int unsigned h);
    case (ph)
      PH_SETUP:  return s;
      PH_STROBE: return w;
      PH_HOLD:   return h;
      default:   return 1;
    endcase
  endfunction

endpackage

// File: rtl/cfpio_phase_ctr.sv
module cfpio_phase_ctr #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] limit_m1_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == limit_m1_i);

  AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !adv_i) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/cfpio_seq.sv
module cfpio_seq import cfpio_pkg::*; #(
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned WIDTH_CYC = 6,
  parameter int unsigned HOLD_CYC  = 2,
  parameter int unsigned CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             ready_i,
  input  logic             cnt_last_i,
  output cfpio_phase_e     phase_o,
  output logic             accept_o,
  output logic             strobe_end_o,
  output logic             cnt_clr_o,
  output logic             cnt_adv_o,
  output logic [CNT_W-1:0] limit_m1_o,
  output logic             done_o
);

  cfpio_phase_e ph_q, ph_d;
  logic         done_q;
  logic         setup_end, hold_end;

  always_comb begin
    accept_o     = (ph_q == PH_IDLE) && req_i;
    setup_end    = (ph_q == PH_SETUP) && cnt_last_i;
    strobe_end_o = (ph_q == PH_STROBE) && ready_i && cnt_last_i;
    hold_end     = (ph_q == PH_HOLD) && cnt_last_i;
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:    if (accept_o)     ph_d = PH_SETUP;
      PH_SETUP:   if (setup_end)    ph_d = PH_STROBE;
      PH_STROBE:  if (strobe_end_o) ph_d = PH_HOLD;
      PH_HOLD:    if (hold_end)     ph_d = (done_q && req_i) ? PH_RELEASE : PH_IDLE;
      PH_RELEASE: if (!req_i)       ph_d = PH_IDLE;
      default:                      ph_d = PH_IDLE;
    endcase
    cnt_clr_o  = (ph_d != ph_q);
    cnt_adv_o  = (ph_q == PH_SETUP) || (ph_q == PH_HOLD) ||
                 ((ph_q == PH_STROBE) && ready_i);
    limit_m1_o = CNT_W'(phase_span(ph_q, SETUP_CYC, WIDTH_CYC, HOLD_CYC) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (strobe_end_o) done_q <= 1'b1;
      else if (!req_i)  done_q <= 1'b0;
    end
  end

  assign phase_o = ph_q;
  assign done_o  = done_q;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && req_i) |=> done_o); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ph_q != PH_STROBE)); // R5
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_RELEASE) && req_i) |=> (ph_q == PH_RELEASE)); // R9

endmodule

// File: rtl/cfpio_hostside.sv
module cfpio_hostside #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              strobe_end_i,
  input  logic              req_we_i,
  input  logic [SEL_W-1:0]  req_sel_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] card_data_i,
  output logic              we_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic rd_capture;
  assign rd_capture = strobe_end_i && !we_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_o    <= 1'b0;
      sel_o   <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      we_o    <= req_we_i;
      sel_o   <= req_sel_i;
      addr_o  <= req_addr_i;
      wdata_o <= req_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_o <= '0;
    else if (rd_capture) rdata_o <= card_data_i;
  end

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable({we_o, sel_o, addr_o, wdata_o})); // R11
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rdata_o)); // R6

endmodule

// File: rtl/cf_pio_timer.sv
module cf_pio_timer import cfpio_pkg::*; #(
  parameter int unsigned SETUP_CYC  = 3,
  parameter int unsigned WIDTH_CYC  = 6,
  parameter int unsigned HOLD_CYC   = 2,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned BUS_ADDR_W = 11,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NUM_CS     = 2,
  localparam int unsigned SEL_W     = idx_bits(NUM_CS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic                  req_we_i,
  input  logic [SEL_W-1:0]      req_sel_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  output logic                  done_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [BUS_ADDR_W-1:0] cf_addr_o,
  output logic [NUM_CS-1:0]     cf_cs_n_o,
  output logic                  cf_rd_n_o,
  output logic                  cf_wr_n_o,
  output logic [DATA_W-1:0]     cf_data_o,
  output logic                  cf_data_oe_o,
  input  logic [DATA_W-1:0]     cf_data_i,
  input  logic                  cf_ready_i
);

  localparam int unsigned CNT_W = idx_bits(max3(SETUP_CYC, WIDTH_CYC, HOLD_CYC));

  if (SETUP_CYC == 0 || WIDTH_CYC == 0 || HOLD_CYC == 0) begin : g_bad_timing
    $error("cf_pio_timer: setup, width and hold counts must be nonzero");
  end
  if (BUS_ADDR_W < ADDR_W) begin : g_bad_addr
    $error("cf_pio_timer: card address narrower than register address");
  end

  cfpio_phase_e     phase;
  logic             accept, strobe_end, cnt_clr, cnt_adv, cnt_last;
  logic [CNT_W-1:0] limit_m1;
  logic             we_q;
  logic [SEL_W-1:0] sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic             cs_act, strobe_act;

  cfpio_seq #(
    .SETUP_CYC(SETUP_CYC), .WIDTH_CYC(WIDTH_CYC), .HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ready_i(cf_ready_i),
    .cnt_last_i(cnt_last), .phase_o(phase), .accept_o(accept),
    .strobe_end_o(strobe_end), .cnt_clr_o(cnt_clr), .cnt_adv_o(cnt_adv),
    .limit_m1_o(limit_m1), .done_o(done_o)
  );

  cfpio_phase_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .adv_i(cnt_adv),
    .limit_m1_i(limit_m1), .last_o(cnt_last)
  );

  cfpio_hostside #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) host_i (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .strobe_end_i(strobe_end),
    .req_we_i(req_we_i), .req_sel_i(req_sel_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .card_data_i(cf_data_i), .we_o(we_q),
    .sel_o(sel_q), .addr_o(addr_q), .wdata_o(cf_data_o), .rdata_o(rdata_o)
  );

  assign cs_act     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobe_act = !cf_rd_n_o || !cf_wr_n_o;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cf_cs_n_o[g] = !(cs_act && (sel_q == SEL_W'(g)));
  end

  assign cf_rd_n_o    = !((phase == PH_STROBE) && !we_q);
  assign cf_wr_n_o    = !((phase == PH_STROBE) && we_q);
  assign cf_data_oe_o = cs_act && we_q;
  assign cf_addr_o    = {{(BUS_ADDR_W-ADDR_W){1'b0}}, addr_q};

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cf_rd_n_o && !cf_wr_n_o)); // R2
  AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cf_cs_n_o)); // R1
  AST_CS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_act) |-> $past(~&cf_cs_n_o)); // R1
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_act) |-> ~&cf_cs_n_o); // R4
  AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cf_data_oe_o |-> (~&cf_cs_n_o && cf_rd_n_o)); // R7

endmodule

// File: tb/cf_pio_timer_tb_top.sv
`timescale 1ns/1ps
module cf_pio_timer_tb_top;

  localparam int S = 2;
  localparam int W = 4;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [0:0]  req_sel = '0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        done;
  logic [15:0] rdata;
  logic [10:0] cf_addr;
  logic [1:0]  cf_cs_n;
  logic        cf_rd_n, cf_wr_n, cf_oe;
  logic [15:0] cf_dout;
  logic [15:0] cf_din = '0;
  logic        cf_ready = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  cf_pio_timer #(.SETUP_CYC(S), .WIDTH_CYC(W), .HOLD_CYC(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we), .req_sel_i(req_sel),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .done_o(done), .rdata_o(rdata),
    .cf_addr_o(cf_addr), .cf_cs_n_o(cf_cs_n), .cf_rd_n_o(cf_rd_n), .cf_wr_n_o(cf_wr_n),
    .cf_data_o(cf_dout), .cf_data_oe_o(cf_oe), .cf_data_i(cf_din), .cf_ready_i(cf_ready)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 lead, 2 pulse, 3 trail, 4 wait for drop
  int          m_ph, m_left;
  bit          m_done, m_we, m_sel, od, set_done;
  logic [2:0]  m_addr;
  logic [15:0] m_wd, m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_done = 0; m_we = 0; m_sel = 0;
      m_addr = '0; m_wd = '0; m_rd = '0;
    end else begin
      od = m_done; set_done = 0;
      case (m_ph)
        0: if (req) begin
             m_ph = 1; m_left = S;
             m_we = req_we; m_sel = req_sel[0]; m_addr = req_addr; m_wd = req_wdata;
           end
        1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = W; end end
        2: if (cf_ready) begin
             m_left--;
             if (m_left == 0) begin
               m_ph = 3; m_left = H; set_done = 1;
               if (!m_we) m_rd = cf_din;
             end
           end
        3: begin m_left--; if (m_left == 0) m_ph = (od && req) ? 4 : 0; end
        default: if (!req) m_ph = 0;
      endcase
      if (set_done) m_done = 1;
      else if (!req) m_done = 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    logic [1:0] e_cs;
    bit act;
    if (rst_n) begin
      act  = (m_ph >= 1 && m_ph <= 3);
      e_cs = 2'b11;
      if (act) e_cs[m_sel] = 1'b0;
      chk(cf_cs_n == e_cs, "R1 chip select", cf_cs_n, e_cs);
      chk({cf_rd_n, cf_wr_n} == {!(m_ph == 2 && !m_we), !(m_ph == 2 && m_we)},
          "R2 strobes", {cf_rd_n, cf_wr_n}, {!(m_ph == 2 && !m_we), !(m_ph == 2 && m_we)});
      chk(done == m_done, "R5 done", done, m_done);
      chk(rdata == m_rd, "R6 read data", rdata, m_rd);
      chk(cf_oe == (act && m_we), "R7 output enable", cf_oe, act && m_we);
      chk(cf_dout == m_wd, "R7 write data", cf_dout, m_wd);
      chk(cf_addr == {8'b0, m_addr}, "R8 address", cf_addr, {8'b0, m_addr});
      cf_din = 16'($urandom);
    end
  end

  task automatic run_cycle(input bit we, input bit sel, input logic [2:0] a,
                           input logic [15:0] wd, input int stalls, input bit setup_stall,
                           input int linger, input bit scramble);
    int cs_first = -1, st_first = -1, st_last = -1, cs_rel = -1, done_first = -1;
    int left = stalls;
    bit strobe, csact;
    @(negedge clk);
    req = 1; req_we = we; req_sel = sel; req_addr = a; req_wdata = wd;
    for (int c = 1; c < 300; c++) begin
      @(negedge clk);
      if (scramble && c > 1) begin   // R11: fields move after acceptance
        req_we = ~we; req_sel = ~sel; req_addr = ~a; req_wdata = ~wd;
      end
      strobe = !cf_rd_n || !cf_wr_n;
      csact  = ~&cf_cs_n;
      if (csact && cs_first < 0) cs_first = c;
      if (strobe && st_first < 0) st_first = c;
      if (strobe) st_last = c;
      if (done && done_first < 0) begin
        done_first = c;
        if (linger == 0) req = 0;
      end
      if (strobe && left > 0) begin cf_ready = 0; left--; end
      else if (setup_stall && csact && st_first < 0) cf_ready = 0;
      else cf_ready = 1;
      if (st_last >= 0 && !csact && cs_rel < 0) begin cs_rel = c; break; end
    end
    cf_ready = 1;
    chk(st_first - cs_first == S, "R1 setup gap", st_first - cs_first, S);
    chk(st_last - st_first + 1 == W + stalls, stalls ? "R3 stretched width" : "R2 width",
        st_last - st_first + 1, W + stalls);
    chk(cs_rel - st_last - 1 == H, "R4 hold gap", cs_rel - st_last - 1, H);
    chk(done_first == st_last + 1, "R5 done rise", done_first, st_last + 1);
    if (scramble) chk(cf_addr[2:0] == a, "R11 address kept", cf_addr[2:0], a);
    if (linger > 0) begin
      for (int i = 0; i < linger; i++) begin
        @(negedge clk);
        chk(cf_cs_n == 2'b11, "R9 no reissue", cf_cs_n, 2'b11);
        chk(done == 1'b1, "R5 done held", done, 1);
      end
      req = 0;
      @(negedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R5 done fall", done, 0);
    end else begin
      chk(done == 1'b0, "R5 early release", done, 0);
    end
    req = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cf_cs_n == 2'b11 && cf_rd_n && cf_wr_n && !cf_oe && !done && cf_addr == 0 && rdata == 0,
        "R10 reset state", {cf_cs_n, cf_rd_n, cf_wr_n, cf_oe, done}, 6'b111100);
    rst_n = 1;
    @(negedge clk);
    chk(cf_cs_n == 2'b11 && cf_rd_n && cf_wr_n && !cf_oe && !done,
        "R10 after reset", {cf_cs_n, cf_rd_n, cf_wr_n, cf_oe, done}, 6'b111100);
    run_cycle(0, 0, 3'd5, 16'h0000, 0, 0, 3, 0);
    run_cycle(1, 1, 3'd2, 16'hA5C3, 0, 0, 0, 0);
    run_cycle(0, 1, 3'd7, 16'h0000, 3, 1, 2, 0);   // R3 stalls plus ready low in setup
    run_cycle(1, 0, 3'd1, 16'h1234, 2, 0, 1, 1);   // R11 scrambled fields
    run_cycle(0, 0, 3'd6, 16'h0000, 0, 1, 0, 1);
    for (int k = 0; k < 8; k++)
      run_cycle(k[0], k[1], 3'(k), 16'($urandom), k % 3, k[2], k % 4, k[1]);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule